// File: doc/BRIEF.md
# Data-Strobe Serial Receiver

This block recovers a serial bit stream from a two-wire data-strobe line pair and delivers it as parallel words to the link clock domain. The two line inputs are first brought into a fast sampling clock domain through synchronizers. Each sampling cycle, the parity of the line pair (data XOR strobe) is compared with its previous value. A parity change marks one new bit, and that bit is the value of the data line.

Bits are assembled most-significant first. A packet at the low speed forms 2-bit words and a packet at the high speed forms 4-bit words. The speed is sampled at the start of each packet. Completed words pass through a small dual-clock FIFO with Gray-coded pointers. They appear on the link clock side one word per valid pulse, tagged with the width they were built at.

The synchronized line pair is also driven out unchanged on a repeat pair, so that other ports can retransmit the stream.

Top module: `ds_rx`

## Requirements
- R1: Each change of the synchronized data XOR strobe parity while rx_en_i is high yields exactly one received bit, equal to the synchronized data line at that moment.
- R2: At the low speed (fast_i = 0 at packet start), every two bits form one word. The first bit received lands in word_o[1] and the second in word_o[0]. word_o[3:2] reads 0 and wide_o reads 0.
- R3: At the high speed (fast_i = 1 at packet start), every four bits form one word, with the first bit in word_o[3] and the last in word_o[0], and wide_o reads 1.
- R4: The speed is captured when rx_en_i rises. A change on fast_i while rx_en_i stays high has no effect on the word width of that packet.
- R5: When rx_en_i falls, any partly assembled word is discarded, and the next packet starts a fresh word.
- R6: Line transitions while rx_en_i is low produce no words.
- R7: Words leave on clk_i in the order they were received, each one marked by a single-cycle valid_o pulse.
- R8: A word completed while the crossing FIFO is full is dropped, and overflow_o goes high and stays high until reset.
- R9: rep_data_o and rep_strobe_o follow data_i and strobe_i through the synchronizer, independently of rx_en_i.
- R10: While rst_ni is low and after its release, valid_o, overflow_o, rep_data_o and rep_strobe_o read 0 until the lines or the packet input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock; read side of the crossing FIFO |
| samp_clk_i | input | 1 | Sampling clock for the line pair; write side |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| data_i | input | 1 | Received data line |
| strobe_i | input | 1 | Received strobe line |
| rx_en_i | input | 1 | High for the duration of a received packet (samp_clk_i domain) |
| fast_i | input | 1 | Speed of the packet: 0 for 2-bit words, 1 for 4-bit words |
| word_o | output | 4 | Received word, first bit most significant |
| wide_o | output | 1 | 1 when word_o carries a 4-bit word |
| valid_o | output | 1 | One-cycle pulse per word on clk_i |
| rep_data_o | output | 1 | Synchronized data line for retransmission |
| rep_strobe_o | output | 1 | Synchronized strobe line for retransmission |
| overflow_o | output | 1 | Sticky flag: a word was lost to a full FIFO (samp_clk_i domain) |

## Verification
The bench sends packets whose lengths are not multiples of the word width. A design that kept the leftover bits would emit a stale extra word, or shift the next packet's words. It flips fast_i in the middle of a packet, which would split the packet into mixed widths if the speed were not held. It toggles the lines with rx_en_i low, which would leak words if the enable were ignored. It also drives one bit per sampling cycle for long enough to fill the FIFO. A design that overwrote full entries would never raise overflow_o, and one that cleared the flag would lose it once the FIFO drained.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  localparam int WORD_W = 4;
  localparam int NARROW_W = 2;

  typedef struct packed {
    logic              wide;
    logic [WORD_W-1:0] bits;
  } word_t;
endpackage

// File: rtl/ds_rx_sync.sv
module ds_rx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ds_rx_line.sv
module ds_rx_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic strobe_i,
  output logic bit_stb_o,
  output logic bit_o,
  output logic rep_data_o,
  output logic rep_strobe_o
);
  logic [1:0] ds_s;
  logic       par, par_q;

  ds_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({data_i, strobe_i}),
    .q_o   (ds_s)
  );

  // recovered clock level: one bit per change
  assign par = ds_s[1] ^ ds_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= 1'b0;
    else         par_q <= par;
  end

  assign bit_stb_o    = par ^ par_q;
  assign bit_o        = ds_s[1];
  assign rep_data_o   = ds_s[1];
  assign rep_strobe_o = ds_s[0];

  AST_STB_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> (ds_s != $past(ds_s))); // R1
endmodule

// File: rtl/ds_rx_deser.sv
module ds_rx_deser
  import ds_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  fast_i,
  input  logic  stb_i,
  input  logic  bit_i,
  output logic  we_o,
  output word_t word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              en_q, spd_q, spd;
  logic [CNT_W-1:0]  cnt_q, last;
  logic [WORD_W-2:0] sh_q;

  // speed taken on the first cycle of a packet, then held
  assign spd  = (en_i && !en_q) ? fast_i : spd_q;
  assign last = spd ? CNT_W'(WORD_W - 1) : CNT_W'(NARROW_W - 1);
  assign we_o = en_i && stb_i && (cnt_q == last);

  always_comb begin
    word_o.wide = spd;
    if (spd) word_o.bits = {sh_q, bit_i};
    else     word_o.bits = {{(WORD_W-NARROW_W){1'b0}}, sh_q[NARROW_W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      spd_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      en_q  <= en_i;
      spd_q <= spd;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (stb_i) begin
        sh_q  <= {sh_q[WORD_W-3:0], bit_i};
        cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R5
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !word_o.wide) |-> (word_o.bits[WORD_W-1:NARROW_W] == '0)); // R2
endmodule

// File: rtl/ds_rx_afifo.sv
module ds_rx_afifo #(
  parameter int W           = 5,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o,
  output logic         ovf_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin_q, wgray_q, rbin_q, rgray_q, rgray_s, wgray_s;
  logic [AW:0]  wbin_n, rbin_n;
  logic         full, empty, push;

  ds_rx_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_s));
  ds_rx_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_s));

  assign full   = (wgray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign empty  = (rgray_q == wgray_s);
  assign push   = we_i && !full;
  assign wbin_n = wbin_q + 1'b1;
  assign rbin_n = rbin_q + 1'b1;

  always_ff @(posedge wclk_i) begin
    if (push) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (push) begin
        wbin_q  <= wbin_n;
        wgray_q <= wbin_n ^ (wbin_n >> 1);
      end
      if (we_i && full) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else if (!empty) begin
      rdata_o  <= mem[rbin_q[AW-1:0]];
      rvalid_o <= 1'b1;
      rbin_q   <= rbin_n;
      rgray_q  <= rbin_n ^ (rbin_n >> 1);
    end else begin
      rvalid_o <= 1'b0;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8
  AST_WPTR_GRAY_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R7
  AST_RPTR_GRAY_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1); // R7
endmodule

// File: rtl/ds_rx.sv
module ds_rx
  import ds_rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              samp_clk_i,
  input  logic              rst_ni,
  input  logic              data_i,
  input  logic              strobe_i,
  input  logic              rx_en_i,
  input  logic              fast_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wide_o,
  output logic              valid_o,
  output logic              rep_data_o,
  output logic              rep_strobe_o,
  output logic              overflow_o
);
  logic  bit_stb, bit_val, we;
  word_t wword, rword;

  ds_rx_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i       (samp_clk_i),
    .rst_ni      (rst_ni),
    .data_i      (data_i),
    .strobe_i    (strobe_i),
    .bit_stb_o   (bit_stb),
    .bit_o       (bit_val),
    .rep_data_o  (rep_data_o),
    .rep_strobe_o(rep_strobe_o)
  );

  ds_rx_deser u_deser (
    .clk_i (samp_clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .fast_i(fast_i),
    .stb_i (bit_stb),
    .bit_i (bit_val),
    .we_o  (we),
    .word_o(wword)
  );

  ds_rx_afifo #(
    .W          ($bits(word_t)),
    .DEPTH      (FIFO_DEPTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_fifo (
    .wclk_i  (samp_clk_i),
    .rclk_i  (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (wword),
    .rdata_o (rword),
    .rvalid_o(valid_o),
    .ovf_o   (overflow_o)
  );

  assign word_o = rword.bits;
  assign wide_o = rword.wide;
endmodule

// File: tb/ds_rx_bench.sv
`timescale 1ns/1ps
module ds_rx_bench;
  localparam int CLK_PERIOD  = 20;
  localparam int SAMP_PERIOD = CLK_PERIOD / 4;
  localparam int NVEC = 6;
  // {fast, nbits, pattern sent from bit 15 downward}
  localparam logic [21:0] VECS [NVEC] = '{
    {1'b0, 5'd8,  16'hA500},
    {1'b1, 5'd8,  16'h3C00},
    {1'b1, 5'd16, 16'h1234},
    {1'b0, 5'd5,  16'hF800},
    {1'b1, 5'd6,  16'hB400},
    {1'b0, 5'd16, 16'h6E91}
  };

  logic clk = 0, sclk = 0, rst_n = 0;
  logic data = 0, strobe = 0, rx_en = 0, fast = 0;
  logic [3:0] word;
  logic wide, valid, rep_d, rep_s, ovf;
  logic dl = 0, sl = 0;
  logic [4:0] got [$];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SAMP_PERIOD/2.0) sclk = ~sclk;

  ds_rx u_ds_rx (
    .clk_i(clk), .samp_clk_i(sclk), .rst_ni(rst_n),
    .data_i(data), .strobe_i(strobe), .rx_en_i(rx_en), .fast_i(fast),
    .word_o(word), .wide_o(wide), .valid_o(valid),
    .rep_data_o(rep_d), .rep_strobe_o(rep_s), .overflow_o(ovf)
  );

  always @(negedge clk) if (valid) got.push_back({wide, word});

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one line changes per bit: data carries the bit, strobe toggles on repeats
  task automatic send_bits(input logic [15:0] pat, input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = pat[15-i];
      if (b == dl) sl = ~sl;
      dl = b;
      data = dl;
      strobe = sl;
      repeat (hold) @(negedge sclk);
    end
  endtask

  task automatic packet(input logic spd, input logic [15:0] pat, input int n);
    @(negedge sclk);
    fast = spd;
    rx_en = 1;
    repeat (3) @(negedge sclk);
    send_bits(pat, n, 3);
    repeat (6) @(negedge sclk);
    rx_en = 0;
    repeat (48) @(negedge sclk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 0 && ovf === 0, "R10 valid/overflow in reset", {valid, ovf}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(valid === 0 && ovf === 0 && rep_d === 0 && rep_s === 0,
          "R10 state after reset", {valid, ovf, rep_d, rep_s}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic spd;
      int n, w, nw;
      logic [15:0] pat;
      spd = VECS[v][21];
      n   = int'(VECS[v][20:16]);
      pat = VECS[v][15:0];
      w   = spd ? 4 : 2;
      nw  = n / w;
      got.delete();
      packet(spd, pat, n);
      check(got.size() == nw, "R5 R7 word count", got.size(), nw);
      for (int k = 0; k < nw && k < got.size(); k++) begin
        logic [4:0] exp;
        exp = {spd, 4'b0};
        for (int j = 0; j < w; j++) exp[w-1-j] = pat[15 - k*w - j];
        check(got[k] == exp, spd ? "R1 R3 wide word" : "R1 R2 narrow word", got[k], exp);
      end
    end

    // R6: transitions with rx_en low
    got.delete();
    send_bits(16'hC3A5, 16, 3);
    repeat (48) @(negedge sclk);
    check(got.size() == 0, "R6 no words while idle", got.size(), 0);

    // R9: repeat pair follows the lines
    @(negedge sclk);
    data = ~dl; dl = ~dl;
    repeat (3) @(negedge sclk);
    check(rep_d === dl && rep_s === sl, "R9 repeat pair", {rep_d, rep_s}, {dl, sl});
    strobe = ~sl; sl = ~sl;
    repeat (3) @(negedge sclk);
    check(rep_d === dl && rep_s === sl, "R9 repeat pair strobe", {rep_d, rep_s}, {dl, sl});

    // R4: speed change mid-packet is ignored
    got.delete();
    @(negedge sclk);
    fast = 0;
    rx_en = 1;
    repeat (2) @(negedge sclk);
    fast = 1;
    send_bits(16'h9C00, 8, 3);
    repeat (6) @(negedge sclk);
    rx_en = 0;
    repeat (48) @(negedge sclk);
    check(got.size() == 4, "R4 narrow words kept", got.size(), 4);
    if (got.size() == 4) begin
      check(got[0] == 5'h02 && got[3] == 5'h00, "R4 word values", {got[0], got[3]}, 10'h040);
    end

    // R8: one bit per sampling cycle fills the FIFO
    check(ovf === 0, "R8 no overflow before burst", ovf, 0);
    @(negedge sclk);
    fast = 0;
    rx_en = 1;
    repeat (3) @(negedge sclk);
    for (int r = 0; r < 6; r++) send_bits(16'hA5C3, 16, 1);
    repeat (4) @(negedge sclk);
    rx_en = 0;
    check(ovf === 1, "R8 overflow raised", ovf, 1);
    repeat (80) @(negedge sclk);
    check(ovf === 1, "R8 overflow sticky", ovf, 1);

    // R10: reset clears the flag and outputs
    @(negedge sclk);
    rst_n = 0;
    dl = 0; sl = 0; data = 0; strobe = 0;
    repeat (2) @(negedge clk);
    check(ovf === 0 && valid === 0, "R10 cleared by reset", {ovf, valid}, 0);
    rst_n = 1;
    got.delete();
    repeat (6) @(negedge clk);
    check(got.size() == 0 && rep_d === 0 && rep_s === 0, "R10 quiet after reset",
          got.size(), 0);

    finish_run();
  end
endmodule